// File: doc/BRIEF.md
# Video Transmitter Interrupt and Reset Controller

This block is the control and interrupt front end of a video transmitter core. Software reaches it over a simple 32-bit register bus. Through that bus it programs the transmitter's configuration fields and chooses which core events may raise an interrupt. It reads and acknowledges pending events and observes live status levels. The core sends single-cycle event pulses for hot-plug change, lock acquisition, new frame, control packet sent, pixel capture and sink termination present. Each pulse is latched into a pending bit that stays set until software acknowledges it. A single level interrupt line is raised while any enabled event is pending.

The block also runs the software-reset handshake. Software sets the reset request field in the configuration register. Reset completion is seen only while that request is held and the audio clock enable input is high. The moment completion first becomes true, a pending event is raised on the same interrupt line the lock event uses. If the audio clock is stopped, no event appears, and software sees a timeout.

Register map: configuration at 0x00, interrupt enable at 0x04, interrupt pending at 0x08, acknowledge (write-one-to-clear) at 0x0C, live status at 0x10. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`. Other offsets read zero, and writes to them are ignored.

Top module: `vtx_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. The configuration register stores only bits 0, 1, 4, 6, 8 and 31, and all other bits read 0. The enable register stores only bits 0, 1, 3, 4, 5, 6, 7 and 11, so writing all ones to it reads back 0x8FB.
- R2: An event pulse sets its pending bit at the next clock edge, and the bit stays set until it is acknowledged. The pending bits are: hot plug = bit 4, lock = bit 5, new frame = bit 6, control packet = bit 7, pixel capture = bit 3, sink termination = bit 11.
- R3: Writing to offset 0x0C clears each pending bit whose write-data bit is 1 and leaves bits written as 0 unchanged. Writing 0xFFFFFFFF clears every pending event.
- R4: When an event arrives in the same cycle as an acknowledge of its bit, the event wins and the bit stays set.
- R5: Pending bit 0 reads as the OR of all other pending bits that are enabled. `irq_o` is high exactly when (pending AND enable) is nonzero.
- R6: An event whose enable bit is 0 still latches its pending bit, but it neither raises `irq_o` nor sets bit 0.
- R7: Writing configuration bit 12 or bit 13 produces a one-cycle pulse on `ovr_clr_o` or `udr_clr_o` respectively, in the cycle after the write. Both bits read back as 0.
- R8: Status bit 1 at offset 0x10 reads 1 only while configuration bit 31 is set and `audio_clk_en` is high. Status bit 5 mirrors `dll_lock_lvl` directly, independent of the lock pending bit.
- R9: Pending bit 1 is set at the clock edge after the reset-done condition of R8 rises. No event is raised while `audio_clk_en` is low, and a condition that stays high raises no second event after an acknowledge.
- R10: Configuration bits drive these outputs: bit 0 drives `dev_en_o`, bit 1 drives `hdmi_mode_o`, bit 4 drives `hsync_neg_o`, bit 6 drives `vsync_neg_o`, bit 8 drives `ycc422_en_o`, and bit 31 drives `sw_rst_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ev_hot_plug | input | 1 | Hot-plug change pulse |
| ev_dll_lock | input | 1 | Lock acquired pulse |
| ev_new_frame | input | 1 | New frame pulse |
| ev_ctrl_pkt | input | 1 | Control packet sent pulse |
| ev_pix_cap | input | 1 | Pixel capture pulse |
| ev_sink_term | input | 1 | Sink termination present pulse |
| dll_lock_lvl | input | 1 | Live lock level |
| audio_clk_en | input | 1 | Audio clock running |
| irq_o | output | 1 | Level interrupt |
| dev_en_o | output | 1 | Device enable |
| hdmi_mode_o | output | 1 | HDMI rather than DVI |
| hsync_neg_o | output | 1 | Negative hsync |
| vsync_neg_o | output | 1 | Negative vsync |
| ycc422_en_o | output | 1 | 4:2:2 enable |
| ovr_clr_o | output | 1 | FIFO overrun clear strobe |
| udr_clr_o | output | 1 | FIFO underrun clear strobe |
| sw_rst_req_o | output | 1 | Software reset request |

## Verification
Some behaviours are checked by assertions on every cycle:
- an event always leaves its pending bit set on the next cycle, even against a simultaneous acknowledge;
- an acknowledge without an event always empties the bit;
- a FIFO clear strobe only follows a configuration write carrying that bit;
- a reset-done event only follows a cycle in which the request was held with the audio clock running.

Other behaviours only the directed scenarios can show: the register map and read-back masks, interrupt masking and the global bit, the live status levels, and the absence of any reset event while the audio clock is stopped or after an acknowledge while completion stays high.

// File: rtl/vtx_irq_pkg.sv
package vtx_irq_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [7:0] OFS_CFG = 8'h00;
  localparam logic [7:0] OFS_EN  = 8'h04;
  localparam logic [7:0] OFS_PND = 8'h08;
  localparam logic [7:0] OFS_ACK = 8'h0C;
  localparam logic [7:0] OFS_STA = 8'h10;

  localparam int unsigned B_GLOBAL = 0;
  localparam int unsigned B_SWRST  = 1;
  localparam int unsigned B_PIXCAP = 3;
  localparam int unsigned B_HPLUG  = 4;
  localparam int unsigned B_LOCK   = 5;
  localparam int unsigned B_FRAME  = 6;
  localparam int unsigned B_PKT    = 7;
  localparam int unsigned B_SINK   = 11;

  localparam int unsigned C_DEV   = 0;
  localparam int unsigned C_HDMI  = 1;
  localparam int unsigned C_HNEG  = 4;
  localparam int unsigned C_VNEG  = 6;
  localparam int unsigned C_422   = 8;
  localparam int unsigned C_OVR   = 12;
  localparam int unsigned C_UDR   = 13;
  localparam int unsigned C_SWREQ = 31;

  localparam logic [REG_W-1:0] CFG_KEEP = 32'h8000_0153;
  localparam logic [REG_W-1:0] EVT_MASK = 32'h0000_08FA;
  localparam logic [REG_W-1:0] EN_KEEP  = EVT_MASK | 32'h1;
endpackage

// File: rtl/vtx_cfg_reg.sv
module vtx_cfg_reg
  import vtx_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] KEEP = CFG_KEEP,
  parameter int unsigned      OVR  = C_OVR,
  parameter int unsigned      UDR  = C_UDR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cfg_q,
  output logic             ovr_stb_q,
  output logic             udr_stb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      ovr_stb_q <= 1'b0;
      udr_stb_q <= 1'b0;
    end else begin
      ovr_stb_q <= wr_en & wdata[OVR];
      udr_stb_q <= wr_en & wdata[UDR];
      if (wr_en) cfg_q <= wdata & KEEP;
    end
  end

  assert_ovr_strobe_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_stb_q |-> $past(wr_en && wdata[OVR]));
  assert_udr_strobe_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    udr_stb_q |-> $past(wr_en && wdata[UDR]));
endmodule

// File: rtl/vtx_evt_latch.sv
module vtx_evt_latch
  import vtx_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = EVT_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= ((pend_q & ~clr_i) | set_i) & MASK;
  end

  for (genvar k = 0; k < REG_W; k++) begin : g_chk
    if (MASK[k]) begin : g_live
      assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[k] |=> pend_q[k]);
      assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[k] && !set_i[k]) |=> !pend_q[k]);
    end
  end
endmodule

// File: rtl/vtx_swrst_hs.sv
module vtx_swrst_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic audio_en_i,
  output logic done_o,
  output logic rise_o
);
  logic done_q;

  assign done_o = req_i & audio_en_i;
  assign rise_o = done_o & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_o;
  end
endmodule

// File: rtl/vtx_irq_ctrl.sv
module vtx_irq_ctrl
  import vtx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ev_hot_plug,
  input  logic              ev_dll_lock,
  input  logic              ev_new_frame,
  input  logic              ev_ctrl_pkt,
  input  logic              ev_pix_cap,
  input  logic              ev_sink_term,
  input  logic              dll_lock_lvl,
  input  logic              audio_clk_en,
  output logic              irq_o,
  output logic              dev_en_o,
  output logic              hdmi_mode_o,
  output logic              hsync_neg_o,
  output logic              vsync_neg_o,
  output logic              ycc422_en_o,
  output logic              ovr_clr_o,
  output logic              udr_clr_o,
  output logic              sw_rst_req_o
);
  localparam logic [ADDR_W-1:0] A_CFG = OFS_CFG[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_EN  = OFS_EN[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_PND = OFS_PND[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_ACK = OFS_ACK[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_STA = OFS_STA[ADDR_W-1:0];

  logic             wr;
  logic [REG_W-1:0] cfg_q, en_q, pend_q, set_v, clr_v, pnd_word, sta_word;
  logic             done, done_rise, any_en;

  assign wr = bus_sel & bus_wr;

  vtx_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && bus_addr == A_CFG),
    .wdata(bus_wdata), .cfg_q(cfg_q), .ovr_stb_q(ovr_clr_o), .udr_stb_q(udr_clr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      en_q <= '0;
    else if (wr && bus_addr == A_EN) en_q <= bus_wdata & EN_KEEP;
  end

  vtx_swrst_hs u_swrst (
    .clk(clk), .rst_n(rst_n), .req_i(cfg_q[C_SWREQ]), .audio_en_i(audio_clk_en),
    .done_o(done), .rise_o(done_rise)
  );

  always_comb begin
    set_v           = '0;
    set_v[B_SWRST]  = done_rise;
    set_v[B_PIXCAP] = ev_pix_cap;
    set_v[B_HPLUG]  = ev_hot_plug;
    set_v[B_LOCK]   = ev_dll_lock;
    set_v[B_FRAME]  = ev_new_frame;
    set_v[B_PKT]    = ev_ctrl_pkt;
    set_v[B_SINK]   = ev_sink_term;
  end

  assign clr_v = (wr && bus_addr == A_ACK) ? bus_wdata : '0;

  vtx_evt_latch u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .pend_q(pend_q)
  );

  assign any_en = |(pend_q & en_q & EVT_MASK);

  always_comb begin
    pnd_word           = pend_q;
    pnd_word[B_GLOBAL] = any_en;
    sta_word           = '0;
    sta_word[B_SWRST]  = done;
    sta_word[B_LOCK]   = dll_lock_lvl;
  end

  assign irq_o = |(pnd_word & en_q);

  always_comb begin
    unique case (bus_addr)
      A_CFG:   bus_rdata = cfg_q;
      A_EN:    bus_rdata = en_q;
      A_PND:   bus_rdata = pnd_word;
      A_STA:   bus_rdata = sta_word;
      default: bus_rdata = '0;
    endcase
  end

  assign dev_en_o     = cfg_q[C_DEV];
  assign hdmi_mode_o  = cfg_q[C_HDMI];
  assign hsync_neg_o  = cfg_q[C_HNEG];
  assign vsync_neg_o  = cfg_q[C_VNEG];
  assign ycc422_en_o  = cfg_q[C_422];
  assign sw_rst_req_o = cfg_q[C_SWREQ];

  assert_swrst_needs_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[B_SWRST]) |-> $past(audio_clk_en && sw_rst_req_o));
  assert_irq_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend_q & en_q & EVT_MASK) != '0));
endmodule

// File: tb/vtx_irq_ctrl_tb.sv
module vtx_irq_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ev_hot_plug = 0, ev_dll_lock = 0, ev_new_frame = 0, ev_ctrl_pkt = 0;
  logic ev_pix_cap = 0, ev_sink_term = 0, dll_lock_lvl = 0, audio_clk_en = 0;
  logic irq_o, dev_en_o, hdmi_mode_o, hsync_neg_o, vsync_neg_o, ycc422_en_o;
  logic ovr_clr_o, udr_clr_o, sw_rst_req_o;
  int   n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  vtx_irq_ctrl u_dut (.*);

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic pulse(ref logic ev);
    ev = 1; @(posedge clk); @(negedge clk); ev = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a <= 16; a += 4) begin
      rd(a[4:0], d); chk("R1 reset read", d, 0);
    end
    chk("R1 reset irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_config;
    logic [31:0] d;
    wr(5'h00, 32'h8000_3153);
    chk("R7 ovr strobe", {31'b0, ovr_clr_o}, 1);
    chk("R7 udr strobe", {31'b0, udr_clr_o}, 1);
    @(negedge clk);
    chk("R7 strobes drop", {30'b0, ovr_clr_o, udr_clr_o}, 0);
    rd(5'h00, d); chk("R1 cfg readback", d, 32'h8000_0153);
    chk("R10 cfg outputs", {26'b0, dev_en_o, hdmi_mode_o, hsync_neg_o, vsync_neg_o,
        ycc422_en_o, sw_rst_req_o}, 6'b111111);
    rd(5'h10, d); chk("R8 no done without audio", d, 0);
    rd(5'h08, d); chk("R9 no event without audio", d, 0);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); chk("R1 cfg mask", d, 32'h8000_0153);
    wr(5'h00, 0);
    rd(5'h00, d); chk("R10 cfg cleared", d, 0);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, d); chk("R1 enable mask", d, 32'h8FB);
  endtask

  task automatic t_events;
    logic [31:0] d;
    wr(5'h04, 32'h8FA);
    pulse(ev_hot_plug);
    rd(5'h08, d); chk("R2 hot plug bit4", d, 32'h11);
    chk("R5 irq high", {31'b0, irq_o}, 1);
    pulse(ev_new_frame);
    rd(5'h08, d); chk("R2 frame bit6", d, 32'h51);
    pulse(ev_ctrl_pkt); pulse(ev_dll_lock);
    rd(5'h08, d); chk("R2 pkt+lock", d, 32'hF1);
    wr(5'h0C, 32'h10);
    rd(5'h08, d); chk("R3 selective ack", d, 32'hE1);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h08, d); chk("R3 ack all", d, 0);
    chk("R5 irq low", {31'b0, irq_o}, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(5'h04, 32'h10);
    pulse(ev_pix_cap);
    rd(5'h08, d); chk("R6 masked latched", d, 32'h08);
    chk("R6 masked no irq", {31'b0, irq_o}, 0);
    pulse(ev_hot_plug);
    rd(5'h08, d); chk("R5 global with enabled", d, 32'h19);
    chk("R5 irq enabled", {31'b0, irq_o}, 1);
    wr(5'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    pulse(ev_sink_term);
    rd(5'h08, d); chk("R2 sink bit11", d, 32'h800);
    ev_sink_term = 1;
    wr(5'h0C, 32'h800);
    ev_sink_term = 0;
    rd(5'h08, d); chk("R4 event beats ack", d, 32'h800);
    wr(5'h0C, 32'h800);
    rd(5'h08, d); chk("R3 ack after", d, 0);
  endtask

  task automatic t_swrst;
    logic [31:0] d;
    wr(5'h04, 32'h2);
    audio_clk_en = 0;
    wr(5'h00, 32'h8000_0000);
    @(negedge clk);
    rd(5'h08, d); chk("R9 stopped clock no event", d, 0);
    chk("R9 no irq", {31'b0, irq_o}, 0);
    audio_clk_en = 1;
    rd(5'h10, d); chk("R8 done level", d, 32'h2);
    @(negedge clk);
    rd(5'h08, d); chk("R9 event on rise", d, 32'h3);
    chk("R9 irq", {31'b0, irq_o}, 1);
    wr(5'h0C, 32'h2);
    @(negedge clk);
    rd(5'h08, d); chk("R9 no repeat event", d, 0);
    wr(5'h00, 0);
    rd(5'h10, d); chk("R8 done drops", d, 0);
    audio_clk_en = 0;
  endtask

  task automatic t_dll;
    logic [31:0] d;
    dll_lock_lvl = 1;
    rd(5'h10, d); chk("R8 lock level", d, 32'h20);
    rd(5'h08, d); chk("R8 level not event", d, 0);
    pulse(ev_dll_lock);
    rd(5'h08, d); chk("R2 lock event bit5", d, 32'h20);
    dll_lock_lvl = 0;
    rd(5'h10, d); chk("R8 lock level low", d, 0);
    rd(5'h08, d); chk("R2 lock event held", d, 32'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_config();
    t_events();
    t_mask();
    t_collision();
    t_swrst();
    t_dll();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule